// File: doc/BRIEF.md
# Three-Wire Control Register File

This block receives 16-bit control words on a three-line serial interface (data, shift clock, latch strobe) and stores them in a small bank of configuration registers. The outputs are the decoded control fields that drive the rest of an audio converter: per-channel attenuation codes with their load bits, soft mute, de-emphasis, output enable, input word length and format, LR clock polarity, common attenuation, filter roll-off, phase reversal, rate select, zero-detect enable, differential output mode and clock-loss detector disable.

The serial lines are oversampled in the `clk` domain. Each line goes through a two-stage synchronizer, and the shift clock and latch strobe go through edge detection. A word counts only when the latch rises after exactly sixteen shift-clock rises, with chip-select low and the device-ready input high. Bits 11 to 9 of the word pick the register. The extended register holds the differential mode and the clock-loss disable. It stays locked after reset until the configuration register has been written with a key.

Top module: `ctl3w_regfile`

## Requirements
- R1: A frame is shifted in MSB first, one bit per rising edge of `ctl_clk`. The frame is committed only on a rising edge of `ctl_ld`.
- R2: Word bits 11..9 select the register: 000 left attenuation, 001 right attenuation, 010 configuration, 011 format, 110 extended. The codes 100, 101 and 111 change nothing. Bits 15..12 are ignored.
- R3: The left register (000) and the right register (001) each hold the attenuation code in bits 7..0 and the load bit in bit 8. After reset the code is 0xFF and the load bit is 0.
- R4: The configuration register (010) holds mute in bit 0, de-emphasis in bit 1, DAC enable in bit 2 and word length in bits 4..3. All of these reset to 0.
- R5: The format register (011) holds the I2S format in bit 0, the LR polarity in bit 1, common attenuation in bit 2, slow roll-off in bit 3, phase reversal in bit 4, rate select in bits 7..6 and zero-detect enable in bit 8. All of these reset to 0.
- R6: A frame latched while `dev_ready` is low changes no output and does not unlock the extended register.
- R7: A frame latched while `ctl_csn` is high changes no output.
- R8: A latch edge that follows any count of shift-clock edges other than 16 is discarded. Every latch edge restarts the count.
- R9: The extended register (110) holds differential mode in bits 5..4 and clock-loss disable in bit 6. Both reset to 0. It is locked after reset, and writes to it while it is locked are dropped.
- R10: An accepted write to the configuration register with bits 8..5 all set unlocks the extended register. It stays unlocked until reset, and later configuration writes without the key do not lock it again.
- R11: An accepted write shows at the outputs on the third rising `clk` edge after the latch rise is presented at the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_ready | input | 1 | High once the device accepts writes |
| ctl_csn | input | 1 | Active-low write enable for the serial port |
| ctl_dat | input | 1 | Serial data |
| ctl_clk | input | 1 | Serial shift clock |
| ctl_ld | input | 1 | Latch strobe, rising edge commits |
| att_left | output | 8 | Left attenuation code |
| load_left | output | 1 | Left attenuation load bit |
| att_right | output | 8 | Right attenuation code |
| load_right | output | 1 | Right attenuation load bit |
| soft_mute | output | 1 | Soft mute |
| deemph_en | output | 1 | De-emphasis enable |
| dac_enable | output | 1 | DAC operation enable |
| word_len | output | 2 | Input word length select |
| fmt_i2s | output | 1 | I2S input format |
| lr_invert | output | 1 | LR clock polarity invert |
| att_common | output | 1 | Common attenuation control |
| slow_rolloff | output | 1 | Slow filter roll-off |
| phase_invert | output | 1 | Output phase reversal |
| rate_sel | output | 2 | Sample-rate select |
| zero_det_en | output | 1 | Zero-detect enable |
| diff_mode | output | 2 | Differential output mode |
| clk_loss_off | output | 1 | Clock-loss detector disable |

## Verification
Every output is a register bit, so a wrong internal state shows on a port within three clocks of the latch edge that caused it. A shift count that is off by one commits a word shifted by one place, so wrong fields appear at once. A lock flag in the wrong state shows only at the next write to the extended register, as changed or unchanged differential-mode bits. For that reason, writes to the extended register are placed right after each lock event. The reference model is compared at every clock, which also catches an update one cycle early or one cycle late.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_LSB = 9;
    localparam int ADDR_W   = 3;
    localparam int KEEP_W   = ADDR_LSB + ADDR_W;
    localparam int ATT_W    = 8;

    localparam logic [ADDR_W-1:0] SEL_ATT_L = 3'b000;
    localparam logic [ADDR_W-1:0] SEL_ATT_R = 3'b001;
    localparam logic [ADDR_W-1:0] SEL_CFG   = 3'b010;
    localparam logic [ADDR_W-1:0] SEL_FMT   = 3'b011;
    localparam logic [ADDR_W-1:0] SEL_EXT   = 3'b110;

    typedef struct packed {
        logic [ATT_W-1:0] att_l;
        logic             ld_l;
        logic [ATT_W-1:0] att_r;
        logic             ld_r;
        logic             mute;
        logic             deemph;
        logic             op_en;
        logic [1:0]       wlen;
        logic             i2s;
        logic             lr_pol;
        logic             att_common;
        logic             slow_roll;
        logic             phase_rev;
        logic [1:0]       rate_sel;
        logic             zdet_en;
        logic [1:0]       diff_mode;
        logic             clkloss_dis;
    } ctl_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int          N         = 1,
    parameter int          STAGES    = 2,
    parameter bit          EMIT_EDGE = 1'b0,
    parameter logic [N-1:0] INIT     = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    localparam int DEPTH = STAGES + (EMIT_EDGE ? 1 : 0);

    logic [N-1:0] chain_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) chain_q[i] <= INIT;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    generate
        if (EMIT_EDGE) begin : g_edge
            assign q = chain_q[STAGES-1] & ~chain_q[STAGES];
        end else begin : g_level
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
    parameter int WORD_W = 16,
    parameter int KEEP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              clk_rise,
    input  logic              latch_rise,
    output logic              word_ok,
    output logic [KEEP_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [KEEP_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        word_ok = 1'b0;
        if (latch_rise) begin
            word_ok   = (st_q.cnt == FULL);
            st_d.cnt  = '0;
        end else if (clk_rise) begin
            st_d.sr = {st_q.sr[KEEP_W-2:0], bit_in};
            if (st_q.cnt != OVER) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;
endmodule

// File: rtl/ctl3w_bank.sv
module ctl3w_bank
    import ctl3w_pkg::*;
#(
    parameter int KEEP_W = ctl3w_pkg::KEEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [KEEP_W-1:0] word,
    output ctl_t              ctl,
    output logic              m4_open
);
    typedef struct packed {
        ctl_t ctl;
        logic open;
    } bank_t;

    localparam ctl_t CTL_RST = '{att_l: '1, att_r: '1, default: '0};

    bank_t st_d, st_q;
    logic [ADDR_W-1:0] sel;

    assign sel = word[ADDR_LSB +: ADDR_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_ATT_L: begin
                    st_d.ctl.att_l = word[ATT_W-1:0];
                    st_d.ctl.ld_l  = word[8];
                end
                SEL_ATT_R: begin
                    st_d.ctl.att_r = word[ATT_W-1:0];
                    st_d.ctl.ld_r  = word[8];
                end
                SEL_CFG: begin
                    st_d.ctl.mute   = word[0];
                    st_d.ctl.deemph = word[1];
                    st_d.ctl.op_en  = word[2];
                    st_d.ctl.wlen   = word[4:3];
                    if (&word[8:5]) st_d.open = 1'b1;
                end
                SEL_FMT: begin
                    st_d.ctl.i2s        = word[0];
                    st_d.ctl.lr_pol     = word[1];
                    st_d.ctl.att_common = word[2];
                    st_d.ctl.slow_roll  = word[3];
                    st_d.ctl.phase_rev  = word[4];
                    st_d.ctl.rate_sel   = word[7:6];
                    st_d.ctl.zdet_en    = word[8];
                end
                SEL_EXT: begin
                    if (st_q.open) begin
                        st_d.ctl.diff_mode   = word[5:4];
                        st_d.ctl.clkloss_dis = word[6];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctl: CTL_RST, open: 1'b0};
        else        st_q <= st_d;
    end

    assign ctl     = st_q.ctl;
    assign m4_open = st_q.open;
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
    import ctl3w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_ready,
    input  logic       ctl_csn,
    input  logic       ctl_dat,
    input  logic       ctl_clk,
    input  logic       ctl_ld,
    output logic [7:0] att_left,
    output logic       load_left,
    output logic [7:0] att_right,
    output logic       load_right,
    output logic       soft_mute,
    output logic       deemph_en,
    output logic       dac_enable,
    output logic [1:0] word_len,
    output logic       fmt_i2s,
    output logic       lr_invert,
    output logic       att_common,
    output logic       slow_rolloff,
    output logic       phase_invert,
    output logic [1:0] rate_sel,
    output logic       zero_det_en,
    output logic [1:0] diff_mode,
    output logic       clk_loss_off
);
    localparam int SYNC_STAGES = 2;

    logic [2:0]        lvl;
    logic [1:0]        rise;
    logic              dat_s, csn_s, rdy_s;
    logic              word_ok, wr_en, m4_open;
    logic [KEEP_W-1:0] word;
    ctl_t              ctl;

    ctl3w_sync #(.N(3), .STAGES(SYNC_STAGES), .EMIT_EDGE(1'b0), .INIT(3'b010)) u_lvl (
        .clk(clk), .rst_n(rst_n), .d({dev_ready, ctl_csn, ctl_dat}), .q(lvl)
    );
    ctl3w_sync #(.N(2), .STAGES(SYNC_STAGES), .EMIT_EDGE(1'b1), .INIT(2'b00)) u_edge (
        .clk(clk), .rst_n(rst_n), .d({ctl_ld, ctl_clk}), .q(rise)
    );

    assign dat_s = lvl[0];
    assign csn_s = lvl[1];
    assign rdy_s = lvl[2];

    ctl3w_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_in(dat_s), .clk_rise(rise[0]),
        .latch_rise(rise[1]), .word_ok(word_ok), .word(word)
    );

    assign wr_en = word_ok & rdy_s & ~csn_s;

    ctl3w_bank #(.KEEP_W(KEEP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word(word),
        .ctl(ctl), .m4_open(m4_open)
    );

    assign att_left     = ctl.att_l;
    assign load_left    = ctl.ld_l;
    assign att_right    = ctl.att_r;
    assign load_right   = ctl.ld_r;
    assign soft_mute    = ctl.mute;
    assign deemph_en    = ctl.deemph;
    assign dac_enable   = ctl.op_en;
    assign word_len     = ctl.wlen;
    assign fmt_i2s      = ctl.i2s;
    assign lr_invert    = ctl.lr_pol;
    assign att_common   = ctl.att_common;
    assign slow_rolloff = ctl.slow_roll;
    assign phase_invert = ctl.phase_rev;
    assign rate_sel     = ctl.rate_sel;
    assign zero_det_en  = ctl.zdet_en;
    assign diff_mode    = ctl.diff_mode;
    assign clk_loss_off = ctl.clkloss_dis;
endmodule

// File: rtl/ctl3w_checks.sv
module ctl3w_checks
    import ctl3w_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              word_ok,
    input logic              rdy_s,
    input logic              csn_s,
    input logic [KEEP_W-1:0] word,
    input ctl_t              ctl,
    input logic              m4_open
);
    a_r6_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && !rdy_s) |=> ($stable(ctl) && $stable(m4_open)));

    a_r7_select_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && csn_s) |=> ($stable(ctl) && $stable(m4_open)));

    a_r1_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ok |=> ($stable(ctl) && $stable(m4_open)));

    a_r3_left_load: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && rdy_s && !csn_s && word[11:9] == SEL_ATT_L)
        |=> (ctl.att_l == $past(word[7:0]) && ctl.ld_l == $past(word[8])));

    a_r9_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && !m4_open && word[11:9] == SEL_EXT)
        |=> ($stable(ctl.diff_mode) && $stable(ctl.clkloss_dis)));

    a_r10_sticky_open: assert property (@(posedge clk) disable iff (!rst_n)
        m4_open |=> m4_open);
endmodule

bind ctl3w_regfile ctl3w_checks u_checks (
    .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .rdy_s(rdy_s),
    .csn_s(csn_s), .word(word), .ctl(ctl), .m4_open(m4_open)
);

// File: tb/ctl3w_regfile_test.sv
module ctl3w_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_ready = 1'b0, ctl_csn = 1'b1, ctl_dat = 1'b0, ctl_clk = 1'b0, ctl_ld = 1'b0;
    logic [7:0] att_left, att_right;
    logic load_left, load_right, soft_mute, deemph_en, dac_enable, fmt_i2s, lr_invert;
    logic att_common, slow_rolloff, phase_invert, zero_det_en, clk_loss_off;
    logic [1:0] word_len, rate_sel, diff_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl3w_regfile uut (
        .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .ctl_csn(ctl_csn),
        .ctl_dat(ctl_dat), .ctl_clk(ctl_clk), .ctl_ld(ctl_ld),
        .att_left(att_left), .load_left(load_left), .att_right(att_right),
        .load_right(load_right), .soft_mute(soft_mute), .deemph_en(deemph_en),
        .dac_enable(dac_enable), .word_len(word_len), .fmt_i2s(fmt_i2s),
        .lr_invert(lr_invert), .att_common(att_common), .slow_rolloff(slow_rolloff),
        .phase_invert(phase_invert), .rate_sel(rate_sel), .zero_det_en(zero_det_en),
        .diff_mode(diff_mode), .clk_loss_off(clk_loss_off)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // behavioural reference state
    int m_att_l, m_ld_l, m_att_r, m_ld_r;
    int m_cfg;      // bits: 0 mute, 1 deemph, 2 enable, 4:3 wlen
    int m_fmt;      // format register image, bit 5 unused
    int m_diff, m_cdd;
    bit m_open;
    bit shifted[$];
    int pend_cnt = 0;
    bit pend_go = 1'b0;
    int pend_word = 0;
    string cur_tag = "R3";

    task automatic model_reset();
        m_att_l = 255; m_ld_l = 0; m_att_r = 255; m_ld_r = 0;
        m_cfg = 0; m_fmt = 0; m_diff = 0; m_cdd = 0; m_open = 1'b0;
        shifted.delete();
        pend_cnt = 0; pend_go = 1'b0;
    endtask

    task automatic model_apply(input int w);
        int a;
        a = (w / 512) % 8;
        if (a == 0) begin m_att_l = w % 256; m_ld_l = (w / 256) % 2; end
        else if (a == 1) begin m_att_r = w % 256; m_ld_r = (w / 256) % 2; end
        else if (a == 2) begin
            m_cfg = w % 32;
            if (((w / 32) % 16) == 15) m_open = 1'b1;
        end
        else if (a == 3) m_fmt = (w % 512) & ~32;
        else if (a == 6 && m_open) begin
            m_diff = (w / 16) % 4; m_cdd = (w / 64) % 2;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        string t;
        // R11: while an update is pending the outputs must still hold the old values
        t = (pend_cnt > 0) ? "R11" : cur_tag;
        chk(t, att_left, m_att_l, "att_left R3");
        chk(t, load_left, m_ld_l, "load_left R3");
        chk(t, att_right, m_att_r, "att_right R3");
        chk(t, load_right, m_ld_r, "load_right R3");
        chk(t, {word_len, dac_enable, deemph_en, soft_mute}, m_cfg, "config R4");
        chk(t, {zero_det_en, rate_sel, 1'b0, phase_invert, slow_rolloff, att_common, lr_invert, fmt_i2s},
            m_fmt, "format R5");
        chk(t, diff_mode, m_diff, "diff_mode R9");
        chk(t, clk_loss_off, m_cdd, "clk_loss_off R9");
    endtask

    task automatic tick();
        @(negedge clk);
        cycles++;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0 && pend_go) model_apply(pend_word);
        end
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send(input string tag, input int w, input int nbits, input bit csn, input bit rdy);
        int acc;
        cur_tag = tag;
        ctl_csn = csn; dev_ready = rdy;
        ticks(4);
        for (int i = 0; i < nbits; i++) begin
            bit b;
            b = (i < 16) ? w[15-i] : 1'b0;   // R1: MSB first
            ctl_dat = b;
            ticks(3);
            ctl_clk = 1'b1;
            shifted.push_back(b);
            ticks(3);
            ctl_clk = 1'b0;
        end
        ticks(2);
        acc = 0;
        foreach (shifted[i]) acc = acc * 2 + shifted[i];
        pend_go   = (shifted.size() == 16) && !csn && rdy;   // R6 R7 R8
        pend_word = acc;
        pend_cnt  = 3;
        shifted.delete();
        ctl_ld = 1'b1;
        ticks(6);
        ctl_ld = 1'b0;
        ticks(4);
        ctl_csn = 1'b1;
        ticks(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        ticks(3);
        rst_n = 1'b1;
        ticks(3);
    endtask

    initial begin
        model_reset();
        cur_tag = "R3";
        ticks(2);
        do_reset();
        // reset state of all fields: R3 R4 R5 R9
        cur_tag = "R9";
        ticks(4);

        send("R6", 16'h0112, 16, 1'b0, 1'b0);              // not ready: dropped
        send("R3", 16'h0112, 16, 1'b0, 1'b1);              // left code 0x12, load 1
        send("R1", 16'h0381, 16, 1'b0, 1'b1);              // right 0x81 load 1, MSB first
        send("R7", 16'h0255, 16, 1'b1, 1'b1);              // chip-select high: dropped
        send("R4", 16'h041B, 16, 1'b0, 1'b1);              // config fields
        send("R5", 16'h075B, 16, 1'b0, 1'b1);              // format fields
        send("R9", 16'h0C70, 16, 1'b0, 1'b1);              // extended locked: dropped
        send("R8", 16'h0033, 15, 1'b0, 1'b1);              // short frame
        send("R8", 16'h0044, 17, 1'b0, 1'b1);              // long frame
        send("R6", 16'h05E0, 16, 1'b0, 1'b0);              // key while not ready: no unlock
        send("R6", 16'h0C70, 16, 1'b0, 1'b1);              // still locked
        send("R10", 16'h05E0, 16, 1'b0, 1'b1);             // key: unlock
        send("R10", 16'h0C70, 16, 1'b0, 1'b1);             // extended now written
        send("R10", 16'h0401, 16, 1'b0, 1'b1);             // config without key
        send("R10", 16'h0C20, 16, 1'b0, 1'b1);             // still open
        send("R2", 16'h08FF, 16, 1'b0, 1'b1);              // code 100 ignored
        send("R2", 16'h0BFF, 16, 1'b0, 1'b1);              // code 101 ignored
        send("R2", 16'h0FFF, 16, 1'b0, 1'b1);              // code 111 ignored
        send("R2", 16'hF0AA, 16, 1'b0, 1'b1);              // upper bits ignored
        send("R5", 16'h06A4, 16, 1'b0, 1'b1);              // other format pattern
        do_reset();
        cur_tag = "R10";
        ticks(2);
        send("R10", 16'h0C70, 16, 1'b0, 1'b1);             // relocked after reset
        send("R3", 16'h0000, 16, 1'b0, 1'b1);              // left code 0, load 0

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule